// File: doc/BRIEF.md
# Programmable USART Baud Clock Generator

This block derives all bit-rate timing for a serial port from the system clock. A 12-bit divisor is written as two byte halves. A down-counter reloads from the divisor every time it runs out, and it emits a one-cycle base tick on each underflow. The base tick rate is therefore fclk/(divisor+1). The receiver consumes the base tick directly as its oversampling strobe. A post-divider turns the same tick into the transmitter bit tick.

Three operating modes select the post-divide ratio and the receiver's sampling state count: asynchronous normal (16), asynchronous double-speed (8) and synchronous master (2). In synchronous master mode a square-wave clock output toggles on every base tick, so its period is one transmit bit. A write to the low byte restarts the prescaler and the post-divider at once. A write to the high byte only stages the upper bits until the next reload.

Top module: `baud_clkgen`

## Requirements
- R1: The divisor is 12 bits: a low-byte write stores bits 7:0 and a high-byte write stores bits 11:8 from `wr_data[3:0]`; `rd_lo` returns the stored low byte and `rd_hi` returns the stored upper bits with bits 7:4 always 0.
- R2: With divisor D, `base_tick` is a one-cycle pulse repeating every D+1 cycles; D = 0 gives a pulse on every cycle.
- R3: A low-byte write reloads the counter with the new full divisor at once; `base_tick` is low in the cycle after the write, and the first tick appears exactly D+1 cycles after the write edge.
- R4: A high-byte write alone neither restarts the counter nor changes `rd_lo`; the new upper bits take effect at the next reload.
- R5: `tx_tick` is a one-cycle pulse repeating every 16 base periods in asynchronous normal mode (`sync_mode`=0, `dbl_speed`=0), every 8 in double-speed mode (`sync_mode`=0, `dbl_speed`=1) and every 2 in synchronous master mode (`sync_mode`=1).
- R6: `dbl_speed` has no effect while `sync_mode` is 1: the rates, `rx_states` and the post-divider phase do not change.
- R7: `rx_states` reports the receiver sampling state count, 16, 8 or 2 by mode as in R5, one cycle after a mode input changes.
- R8: A low-byte write or a change of effective mode clears the post-divider, so the first `tx_tick` after a low-byte write comes one cycle after the N-th following base tick (N from R5).
- R9: In synchronous master mode `sck_out` toggles on each base tick, giving a 50% duty square wave with a period of 2(D+1) cycles; in asynchronous modes it stays low.
- R10: While `rst` is high and in the cycle after it, `base_tick`, `tx_tick` and `sck_out` are low; reset leaves the divisor at 0 and the mode at asynchronous normal (`rx_states` = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe for the low divisor byte |
| wr_hi | input | 1 | Write strobe for the high divisor byte |
| wr_data | input | 8 | Write data for either byte |
| sync_mode | input | 1 | 1 selects synchronous master mode |
| dbl_speed | input | 1 | 1 selects double speed in asynchronous mode |
| rd_lo | output | 8 | Stored low divisor byte |
| rd_hi | output | 8 | Stored upper divisor bits, zero-extended |
| base_tick | output | 1 | Receiver oversample strobe, one pulse per base period |
| tx_tick | output | 1 | Transmitter bit strobe |
| sck_out | output | 1 | Synchronous master clock output |
| rx_states | output | 5 | Receiver sampling state count for the current mode |

## Verification
The assertions assume that `wr_lo` and `wr_hi` are never raised in the same cycle. They also assume that the mode inputs hold steady for longer than one base period whenever phase is checked. The stimulus writes one byte per task call, each strobe lasting exactly one cycle, and it changes the mode inputs only before the byte writes that start each configuration. Every configuration then runs for at least three transmit bit periods before any rate is measured, so each measured interval lies wholly inside one configuration.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC_NORM  = 2'd0,
    MODE_ASYNC_FAST  = 2'd1,
    MODE_SYNC_MASTER = 2'd2
  } baud_mode_e;

  // Post-divide ratio for a mode, ratios supplied by the instantiating block.
  function automatic int unsigned mode_ratio(baud_mode_e m, int unsigned r_norm,
                                             int unsigned r_fast, int unsigned r_sync);
    case (m)
      MODE_ASYNC_FAST:  return r_fast;
      MODE_SYNC_MASTER: return r_sync;
      default:          return r_norm;
    endcase
  endfunction

endpackage

// File: rtl/baud_divreg.sv
module baud_divreg #(
  parameter int DIV_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_o,
  output logic [DIV_W-1:0]  load_val_o,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= wr_data[HI_W-1:0];
    end
  end

  assign div_o      = {hi_q, lo_q};
  // Full value loaded on a low-byte write: staged upper bits plus new low byte.
  assign load_val_o = {hi_q, wr_data};
  assign rd_lo      = lo_q;
  assign rd_hi      = {{(BYTE_W-HI_W){1'b0}}, hi_q};

  p_hi_store_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (rd_hi == {{(BYTE_W-HI_W){1'b0}}, $past(wr_data[HI_W-1:0])}));

  p_hi_keeps_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> (rd_lo == $past(rd_lo)));

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] reload_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload_val;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  p_load_restart_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (!tick && cnt == $past(load_val)));

  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (!tick && cnt == $past(cnt) - 1'b1));

  p_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> (tick && cnt == $past(reload_val)));

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv #(
  parameter int PC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            tick_in,
  input  logic            sync_en,
  input  logic [PC_W-1:0] last,
  output logic            tx_tick,
  output logic            sck
);
  logic [PC_W-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc      <= '0;
      tx_tick <= 1'b0;
      sck     <= 1'b0;
    end else begin
      tx_tick <= 1'b0;
      if (tick_in) begin
        if (pc == last) begin
          pc      <= '0;
          tx_tick <= 1'b1;
        end else begin
          pc <= pc + 1'b1;
        end
        if (sync_en) sck <= ~sck;
      end
    end
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc == '0 && !tx_tick && !sck));

  p_tx_from_tick_r5: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> $past(tick_in));

  p_pc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && pc <= last) |=> (pc <= $past(last)));

  p_sck_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick_in && sync_en) |=> (sck != $past(sck)));

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!sync_en && !sck) |=> !sck);

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
  parameter int DIV_W      = 12,
  parameter int BYTE_W     = 8,
  parameter int RATIO_NORM = 16,
  parameter int RATIO_FAST = 8,
  parameter int RATIO_SYNC = 2,
  localparam int PC_W      = $clog2(RATIO_NORM),
  localparam int RS_W      = PC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              sync_mode,
  input  logic              dbl_speed,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi,
  output logic              base_tick,
  output logic              tx_tick,
  output logic              sck_out,
  output logic [RS_W-1:0]   rx_states
);
  import baud_pkg::*;

  baud_mode_e       mode_eff, mode_q;
  logic             mode_chg, pd_clr;
  logic [DIV_W-1:0] div_val, load_val;
  logic [PC_W-1:0]  pd_last;

  // Double speed only counts when the port is asynchronous.
  always_comb begin
    if (sync_mode)      mode_eff = MODE_SYNC_MASTER;
    else if (dbl_speed) mode_eff = MODE_ASYNC_FAST;
    else                mode_eff = MODE_ASYNC_NORM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_ASYNC_NORM;
      rx_states <= RS_W'(RATIO_NORM);
    end else begin
      mode_q    <= mode_eff;
      rx_states <= RS_W'(mode_ratio(mode_eff, RATIO_NORM, RATIO_FAST, RATIO_SYNC));
    end
  end

  assign mode_chg = (mode_eff != mode_q);
  assign pd_clr   = mode_chg || wr_lo;
  assign pd_last  = PC_W'(mode_ratio(mode_q, RATIO_NORM, RATIO_FAST, RATIO_SYNC) - 1);

  baud_divreg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_divreg (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .div_o(div_val), .load_val_o(load_val), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .load(wr_lo), .load_val(load_val),
    .reload_val(div_val), .tick(base_tick)
  );

  baud_postdiv #(.PC_W(PC_W)) u_postdiv (
    .clk(clk), .rst(rst), .clr(pd_clr), .tick_in(base_tick),
    .sync_en(mode_q == MODE_SYNC_MASTER), .last(pd_last),
    .tx_tick(tx_tick), .sck(sck_out)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!base_tick && !tx_tick && !sck_out));

  p_rx_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(rx_states) == 1);

  p_sync_ignores_dbl_r6: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && $past(sync_mode)) |-> (rx_states == RS_W'(RATIO_SYNC)));

endmodule

// File: tb/baud_clkgen_test.sv
`timescale 1ns/1ps
module baud_clkgen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0] wr_data = '0;
  logic       sync_mode = 1'b0, dbl_speed = 1'b0;
  logic [7:0] rd_lo, rd_hi;
  logic       base_tick, tx_tick, sck_out;
  logic [4:0] rx_states;

  always #2.5 clk = ~clk;

  baud_clkgen uut (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .sync_mode(sync_mode), .dbl_speed(dbl_speed), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .base_tick(base_tick), .tx_tick(tx_tick), .sck_out(sck_out), .rx_states(rx_states)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // Interval monitor, sampled away from the active edge.
  int cyc = 0, last_b = 0, per_b = 0, last_t = 0, per_t = 0;
  int last_r = 0, per_r = 0, run = 0, hi_len = 0, sck_hi_cnt = 0;
  bit prev_sck = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (base_tick) begin per_b = cyc - last_b; last_b = cyc; end
    if (tx_tick)   begin per_t = cyc - last_t; last_t = cyc; end
    if (sck_out && !prev_sck) begin per_r = cyc - last_r; last_r = cyc; run = 1; end
    else if (sck_out) run++;
    else if (prev_sck) hi_len = run;
    if (sck_out) sck_hi_cnt++;
    prev_sck = sck_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_hi = hi; wr_lo = !hi; wr_data = d;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  // {sync, dbl, divisor[11:0], base period[15:0], tx period[15:0]}
  localparam int NV = 8;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'd3, 16'd4,  16'd64},
    {1'b0, 1'b1, 12'd3, 16'd4,  16'd32},
    {1'b1, 1'b0, 12'd3, 16'd4,  16'd8},
    {1'b1, 1'b1, 12'd3, 16'd4,  16'd8},
    {1'b0, 1'b0, 12'd0, 16'd1,  16'd16},
    {1'b0, 1'b1, 12'd9, 16'd10, 16'd80},
    {1'b1, 1'b0, 12'd0, 16'd1,  16'd2},
    {1'b0, 1'b0, 12'd6, 16'd7,  16'd112}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int fb, ft;
    // Reset state (R10)
    repeat (3) @(negedge clk);
    check(!base_tick && !tx_tick && !sck_out, "R10 outputs quiet in reset",
          {base_tick, tx_tick, sck_out}, 0);
    check(rx_states == 5'd16, "R10 rx_states after reset", rx_states, 16);
    check(rd_lo == 8'd0 && rd_hi == 8'd0, "R10 divisor zero after reset", {rd_hi, rd_lo}, 0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    fb = base_tick;
    @(negedge clk);
    check(fb == 1 && base_tick, "R2 divisor 0 ticks every cycle", fb + base_tick, 2);

    // Vector table: rates, state count and master clock per mode
    for (int i = 0; i < NV; i++) begin
      int eb, et, er, w;
      eb = int'(VEC[i][31:16]);
      et = int'(VEC[i][15:0]);
      er = VEC[i][45] ? 2 : (VEC[i][44] ? 8 : 16);
      @(negedge clk);
      sync_mode = VEC[i][45]; dbl_speed = VEC[i][44];
      wr(1'b1, {4'h0, VEC[i][43:40]});
      wr(1'b0, VEC[i][39:32]);
      sck_hi_cnt = 0;
      w = 3 * et + 8;
      repeat (w) @(negedge clk);
      check(per_b == eb, $sformatf("R2 base period vec %0d", i), per_b, eb);
      check(per_t == et, $sformatf("R5 tx period vec %0d", i), per_t, et);
      check(int'(rx_states) == er, $sformatf("R7 rx_states vec %0d", i), rx_states, er);
      if (VEC[i][45]) begin
        check(per_r == 2 * eb, $sformatf("R9 sck period vec %0d", i), per_r, 2 * eb);
        check(hi_len == eb, $sformatf("R9 sck high time vec %0d", i), hi_len, eb);
        if (VEC[i][44])
          check(per_t == et && rx_states == 5'd2, "R6 dbl_speed ignored in sync", per_t, et);
      end else begin
        check(sck_hi_cnt == 0, $sformatf("R9 sck low in async vec %0d", i), sck_hi_cnt, 0);
      end
    end

    // R3 / R8: low-byte write restarts prescaler and post-divider (normal mode)
    @(negedge clk);
    sync_mode = 1'b0; dbl_speed = 1'b0;
    wr(1'b1, 8'h00);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'd20);
    fb = 0; ft = 0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (base_tick && fb == 0) fb = k;
      if (tx_tick && ft == 0) ft = k;
    end
    check(fb == 21, "R3 first base tick after low write", fb, 21);
    check(ft == 337, "R8 first tx tick after low write", ft, 337);

    // R1 / R4: high-byte write stages upper bits without restarting
    wr(1'b1, 8'hF1);
    check(rd_hi == 8'h01, "R1 high byte reads back upper bits only", rd_hi, 1);
    check(rd_lo == 8'd20, "R4 low byte unchanged by high write", rd_lo, 20);
    fb = 0;
    for (int k = 1; k <= 300 && fb == 0; k++) begin
      @(negedge clk);
      if (base_tick) fb = k;
    end
    check(fb >= 1 && fb <= 21, "R4 no restart on high write", fb, 21);
    repeat (700) @(negedge clk);
    check(per_b == 277, "R4 new divisor after reload", per_b, 277);

    // R10: reset mid-operation
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!base_tick && !tx_tick && !sck_out && rd_hi == 8'd0, "R10 reset clears state",
          {base_tick, tx_tick, sck_out}, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule